// File: doc/BRIEF.md
# Shift and Rotate Unit for a 32-bit Integer Datapath

This unit prepares the second operand of an integer datapath. It shifts or rotates a 32-bit word left or right. The amount comes either from a 5-bit field held in an instruction or from the low byte of a 32-bit register value. The unit returns the shifted word and a shifter carry, which a later stage may copy into the condition flags. The result and the carry are registered and appear one clock after the inputs are taken.

An immediate amount of zero does not always mean "no shift". With a left shift it is a plain pass-through. With the two right shifts it stands for a shift by 32. With a rotate it selects a one-bit rotate through the incoming carry. A register amount can reach 255, so amounts of 32 and above saturate. The upper bits of that byte are OR-reduced into one overflow indicator, which keeps the shift network only five bits wide. A common use is scaling a table index by a left shift of 2 for word entries or of 1 for halfword entries.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low, `resultOut` is 0 and `carryOut` is 0.
- R2: The inputs present at a rising clock edge set `resultOut` and `carryOut` after that edge. Between edges the outputs hold.
- R3: When `useRegAmount` is 1, the amount is `regAmount[7:0]` and bits 31:8 have no effect.
- R4: `shiftKind` encodes 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. For an amount n from 1 to 31, the carry is the last bit moved out: bit 32-n for a left shift, and bit n-1 for the right shifts and the rotate.
- R5: An immediate amount of 0 with a logical left shift gives the operand unchanged, and the carry equals `carryIn`.
- R6: An immediate amount of 0 with a logical or arithmetic right shift acts as a shift by 32.
- R7: An immediate amount of 0 with a rotate gives `{carryIn, operand[31:1]}`, and the carry equals operand bit 0.
- R8: A register amount of 0 gives the operand unchanged with the carry equal to `carryIn`, for every shift kind.
- R9: A logical shift by exactly 32 gives 0. The carry is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R10: A logical shift by a register amount above 32 gives a result of 0 and a carry of 0.
- R11: An arithmetic right shift by 32 or more sets every result bit, and the carry, to operand bit 31.
- R12: A rotate by a register amount uses only bits 4:0 of the amount. A nonzero amount whose low 5 bits are 0 gives the operand unchanged, and the carry equals operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| operandIn | input | 32 | Word to shift or rotate |
| shiftKind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| immAmount | input | 5 | Amount taken from the instruction field |
| regAmount | input | 32 | Register value; its low byte is the amount |
| useRegAmount | input | 1 | 1 selects the register amount, 0 the immediate amount |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted or rotated word, registered |
| carryOut | output | 1 | Shifter carry, registered |

## Verification
The bench drives the immediate-zero cases of all four kinds. A unit that treated them all as "no shift" would return the operand where a zero or sign fill is due, or would lose the carry-in bit that a one-bit rotate must insert. It sweeps register amounts of 0, 31, 32, 33, 64 and 255 and sets bits 31:8 of the register to junk. A unit with a wrong saturation rule would leak a stale carry at exactly 32. One that masked the amount to five bits would wrap a shift by 33 into a shift by 1, and one that read the upper bits would shift by a huge amount. Rotates by nonzero multiples of 32 check that the carry comes from bit 31 and not from `carryIn`. Random words and amounts are compared against a bench model that shifts one bit at a time.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int WORD_W    = 32;
  localparam int AMT_W     = $clog2(WORD_W);
  localparam int REG_AMT_W = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shiftKind_e;

  // Strobes from the amount decoder to the shift network
  typedef struct packed {
    logic             passThru;  // operand and carry through unchanged
    logic             rrxMode;   // one-bit rotate through carry
    logic             saturate;  // amount is WORD_W or more (non-rotate)
    logic             exactWord; // amount is exactly WORD_W
    logic [AMT_W-1:0] amt;       // low bits of the effective amount
    shiftKind_e       kind;
  } shiftStrobes_t;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic [1:0]       shiftKind,
  input  logic [AMT_W-1:0] immAmount,
  input  logic [WORD_W-1:0] regAmount,
  input  logic             useRegAmount,
  output shiftStrobes_t    strobes
);

  logic [REG_AMT_W-1:0] amtByte;
  logic                 highBits;
  logic                 immZero;
  shiftKind_e           kindE;

  assign kindE    = shiftKind_e'(shiftKind);
  assign amtByte  = useRegAmount ? regAmount[REG_AMT_W-1:0]
                                 : {{(REG_AMT_W-AMT_W){1'b0}}, immAmount};
  // OR-reduce the bits above the shift network into one indicator
  assign highBits = |amtByte[REG_AMT_W-1:AMT_W];
  assign immZero  = !useRegAmount && (immAmount == '0);

  always_comb begin
    strobes.kind      = kindE;
    strobes.amt       = amtByte[AMT_W-1:0];
    strobes.passThru  = 1'b0;
    strobes.rrxMode   = 1'b0;
    strobes.saturate  = 1'b0;
    strobes.exactWord = 1'b0;
    if (useRegAmount) begin
      if (amtByte == '0) begin
        strobes.passThru = 1'b1;
      end else if (kindE != SK_ROR) begin
        strobes.saturate  = highBits;
        strobes.exactWord = (amtByte == REG_AMT_W'(WORD_W));
      end
    end else if (immZero) begin
      unique case (kindE)
        SK_LSL: strobes.passThru = 1'b1;
        SK_ROR: strobes.rrxMode  = 1'b1;
        default: begin
          strobes.saturate  = 1'b1;
          strobes.exactWord = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
(
  input  shiftStrobes_t     strobes,
  input  logic [WORD_W-1:0] operand,
  input  logic              carryIn,
  output logic [WORD_W-1:0] result,
  output logic              carry
);

  logic [WORD_W:0]     leftExt;
  logic [WORD_W:0]     rightExt;
  logic [WORD_W:0]     arithExt;
  logic [2*WORD_W-1:0] rotExt;
  logic                signBit;

  assign signBit  = operand[WORD_W-1];
  assign leftExt  = {1'b0, operand} << strobes.amt;
  assign rightExt = {operand, 1'b0} >> strobes.amt;
  assign arithExt = $unsigned($signed({operand, 1'b0}) >>> strobes.amt);
  assign rotExt   = {operand, operand} >> strobes.amt;

  always_comb begin
    result = operand;
    carry  = carryIn;
    if (strobes.passThru) begin
      result = operand;
      carry  = carryIn;
    end else if (strobes.rrxMode) begin
      result = {carryIn, operand[WORD_W-1:1]};
      carry  = operand[0];
    end else begin
      unique case (strobes.kind)
        SK_LSL: begin
          if (strobes.saturate) begin
            result = '0;
            carry  = strobes.exactWord & operand[0];
          end else begin
            result = leftExt[WORD_W-1:0];
            carry  = leftExt[WORD_W];
          end
        end
        SK_LSR: begin
          if (strobes.saturate) begin
            result = '0;
            carry  = strobes.exactWord & signBit;
          end else begin
            result = rightExt[WORD_W:1];
            carry  = rightExt[0];
          end
        end
        SK_ASR: begin
          if (strobes.saturate) begin
            result = {WORD_W{signBit}};
            carry  = signBit;
          end else begin
            result = arithExt[WORD_W:1];
            carry  = arithExt[0];
          end
        end
        default: begin
          // amount 0 here means a nonzero multiple of the word width
          result = rotExt[WORD_W-1:0];
          carry  = rotExt[WORD_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] operandIn,
  input  logic [1:0]        shiftKind,
  input  logic [AMT_W-1:0]  immAmount,
  input  logic [WORD_W-1:0] regAmount,
  input  logic              useRegAmount,
  input  logic              carryIn,
  output logic [WORD_W-1:0] resultOut,
  output logic              carryOut
);

  shiftStrobes_t     strobes;
  logic [WORD_W-1:0] nextResult;
  logic              nextCarry;

  bsu_ctrl u_ctrl (
    .shiftKind    (shiftKind),
    .immAmount    (immAmount),
    .regAmount    (regAmount),
    .useRegAmount (useRegAmount),
    .strobes      (strobes)
  );

  bsu_datapath u_dp (
    .strobes  (strobes),
    .operand  (operandIn),
    .carryIn  (carryIn),
    .result   (nextResult),
    .carry    (nextCarry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultOut <= '0;
      carryOut  <= 1'b0;
    end else begin
      resultOut <= nextResult;
      carryOut  <= nextCarry;
    end
  end

  // Checks on the registered outputs against the inputs of the previous cycle
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (resultOut == '0 && carryOut == 1'b0));

  p_zero_reg_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(useRegAmount) && $past(regAmount[REG_AMT_W-1:0]) == '0)
    |-> (resultOut == $past(operandIn) && carryOut == $past(carryIn)));

  p_rrx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(useRegAmount) && $past(immAmount) == '0 && $past(shiftKind) == 2'b11)
    |-> (resultOut == {$past(carryIn), $past(operandIn[WORD_W-1:1])}
         && carryOut == $past(operandIn[0])));

  p_logic_over_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(useRegAmount) && $past(shiftKind[1]) == 1'b0
     && $past(regAmount[REG_AMT_W-1:0]) > REG_AMT_W'(WORD_W))
    |-> (resultOut == '0 && carryOut == 1'b0));

  p_sign_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(useRegAmount) && $past(shiftKind) == 2'b10
     && $past(regAmount[REG_AMT_W-1:0]) >= REG_AMT_W'(WORD_W))
    |-> (resultOut == {WORD_W{$past(operandIn[WORD_W-1])}}
         && carryOut == $past(operandIn[WORD_W-1])));

  p_rot_multiple_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(useRegAmount) && $past(shiftKind) == 2'b11
     && $past(regAmount[AMT_W-1:0]) == '0 && $past(regAmount[REG_AMT_W-1:0]) != '0)
    |-> (resultOut == $past(operandIn) && carryOut == $past(operandIn[WORD_W-1])));

endmodule

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operandIn = '0;
  logic [1:0]  shiftKind = '0;
  logic [4:0]  immAmount = '0;
  logic [31:0] regAmount = '0;
  logic        useRegAmount = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rst_n(rst_n), .operandIn(operandIn), .shiftKind(shiftKind),
    .immAmount(immAmount), .regAmount(regAmount), .useRegAmount(useRegAmount),
    .carryIn(carryIn), .resultOut(resultOut), .carryOut(carryOut)
  );

  // Reference: one-bit steps, repeated for the effective amount
  function automatic logic [32:0] refModel(input logic [31:0] op, input logic [1:0] kind,
      input logic [4:0] imm, input logic [31:0] ra, input logic useR, input logic cin);
    logic [31:0] x;
    logic        c;
    int          n;
    x = op;
    c = cin;
    if (useR) n = int'(ra[7:0]);
    else if (imm != 0) n = int'(imm);
    else begin
      case (kind)
        2'b00: n = 0;
        2'b11: return {op[0], cin, op[31:1]};
        default: n = 32;
      endcase
    end
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'b00: begin c = x[31]; x = {x[30:0], 1'b0}; end
        2'b01: begin c = x[0];  x = {1'b0, x[31:1]}; end
        2'b10: begin c = x[0];  x = {x[31], x[31:1]}; end
        default: begin c = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {c, x};
  endfunction

  task automatic check(input string tag, input logic [31:0] expR, input logic expC);
    checks++;
    if (resultOut !== expR || carryOut !== expC) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               tag, resultOut, carryOut, expR, expC);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] op, input logic [1:0] kind,
      input logic [4:0] imm, input logic [31:0] ra, input logic useR, input logic cin);
    logic [32:0] e;
    @(negedge clk);
    operandIn = op; shiftKind = kind; immAmount = imm;
    regAmount = ra; useRegAmount = useR; carryIn = cin;
    e = refModel(op, kind, imm, ra, useR, cin);
    @(posedge clk);
    #2;
    check(tag, e[31:0], e[32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] prevR;
    logic        prevC;
    void'($urandom(32'h5EED_1234));
    operandIn = 32'hDEAD_BEEF; carryIn = 1'b1; shiftKind = 2'b00;
    immAmount = 5'd3; useRegAmount = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 basic kinds and index scaling
    run("R4 lsl2 index", 32'h0000_0007, 2'b00, 5'd2, '0, 1'b0, 1'b0);
    run("R4 lsl1 index", 32'h8000_0005, 2'b00, 5'd1, '0, 1'b0, 1'b0);
    run("R4 lsr 4", 32'hF000_000F, 2'b01, 5'd4, '0, 1'b0, 1'b0);
    run("R4 asr 31", 32'h8000_0000, 2'b10, 5'd31, '0, 1'b0, 1'b0);
    run("R4 ror 8", 32'h1234_5680, 2'b11, 5'd8, '0, 1'b0, 1'b0);

    // R2: outputs hold until the next edge
    prevR = resultOut; prevC = carryOut;
    @(negedge clk);
    operandIn = 32'hFFFF_FFFF; shiftKind = 2'b00; immAmount = 5'd0; carryIn = 1'b0;
    #5;
    check("R2 hold between edges", prevR, prevC);
    @(posedge clk); #2;
    check("R2 update after edge", 32'hFFFF_FFFF, 1'b0);

    run("R5 imm lsl 0", 32'hA5A5_0001, 2'b00, 5'd0, '0, 1'b0, 1'b1);
    run("R6 imm lsr 0", 32'h8000_0001, 2'b01, 5'd0, '0, 1'b0, 1'b0);
    check("R6 lsr32 value", 32'h0, 1'b1);
    run("R6 imm asr 0", 32'h7FFF_FFFF, 2'b10, 5'd0, '0, 1'b0, 1'b1);
    check("R6 asr32 value", 32'h0, 1'b0);
    run("R7 imm ror 0", 32'h0000_0003, 2'b11, 5'd0, '0, 1'b0, 1'b1);
    check("R7 rrx value", 32'h8000_0001, 1'b1);
    for (int k = 0; k < 4; k++)
      run("R8 reg amount 0", 32'h1357_9BDF, 2'(k), 5'd7, 32'hABCD_EF00, 1'b1, 1'b1);
    run("R3 upper bits ignored", 32'h0000_00F0, 2'b01, 5'd0, 32'hFFFF_FF04, 1'b1, 1'b1);
    check("R3 shift by 4", 32'h0000_000F, 1'b0);
    run("R9 lsl 32", 32'h0000_0001, 2'b00, 5'd0, 32'd32, 1'b1, 1'b0);
    run("R9 lsr 32", 32'h8000_0000, 2'b01, 5'd0, 32'd32, 1'b1, 1'b0);
    run("R10 lsl 33", 32'hFFFF_FFFF, 2'b00, 5'd0, 32'd33, 1'b1, 1'b1);
    run("R10 lsr 255", 32'hFFFF_FFFF, 2'b01, 5'd0, 32'd255, 1'b1, 1'b1);
    run("R11 asr 32 neg", 32'h8000_0000, 2'b10, 5'd0, 32'd32, 1'b1, 1'b0);
    run("R11 asr 200 pos", 32'h7FFF_FFFF, 2'b10, 5'd0, 32'd200, 1'b1, 1'b1);
    run("R12 ror 64", 32'h8000_1234, 2'b11, 5'd0, 32'd64, 1'b1, 1'b0);
    run("R12 ror 37", 32'h0000_0010, 2'b11, 5'd0, 32'd37, 1'b1, 1'b0);
    run("R12 ror 32", 32'h4000_0000, 2'b11, 5'd0, 32'd32, 1'b1, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra;
      logic [31:0] sel;
      sel = $urandom % 4;
      ra = $urandom;
      if (sel == 0) ra[7:0] = 8'($urandom % 41);
      else if (sel == 1) ra[7:0] = 8'(28 + ($urandom % 10));
      run("R4 random", $urandom, 2'($urandom), 5'($urandom), ra, 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule